// File: doc/BRIEF.md
# Trace Packet Overflow Controller

This block sits between the raw trace packet source of one hart and the path toward a funnel or sink. Packets arrive as a beat stream with a last-beat marker. The length of each packet is carried in its first beat. The block keeps an internal FIFO that can hold several packets to absorb bursts. Before it accepts the first beat of a packet, it checks that the whole packet fits in the free FIFO entries. As a result, the downstream side only ever sees complete packets.

When a packet cannot fit, the configured mode decides what happens. In the non-intrusive mode, the whole packet is swallowed and discarded, so the hart never waits. The block then refuses new packets until the FIFO has drained to a programmable level, which avoids a long run of short trace fragments. After that it writes a one-beat synchronization word ahead of the next packet it forwards, so a decoder learns that some trace was lost. In the stall mode, the packet is instead held at the input and a stall request goes to the hart until room appears. Two status outputs report losses: a sticky overflow flag and a saturating drop counter. An enable input quiets the whole block.

Top module: `trc_ovf_ctrl`

## Requirements
- R1: The first beat of a packet is taken only when the free FIFO entries are at least the packet's beat count, plus one if a synchronization word is pending. The beat count is the value in bits [LEN_W-1:0] of the first beat plus one. Once a packet is taken, all of its beats are written in order with no gap from other packets.
- R2: In non-intrusive mode (`stall_mode`=0), a packet that does not fit is consumed beat by beat with `in_ready` high, and none of its beats reach the FIFO.
- R3: After any dropped packet, the next forwarded packet is preceded in the FIFO by a single synchronization beat. This beat has bits [DATA_W-1:DATA_W-4] equal to 4'hF, all other data bits 0, and its last marker set.
- R4: After a drop, every arriving packet is also dropped, even one that would fit, while the FIFO occupancy is above `hyst_lvl`. Packets are admitted again once the occupancy is at or below `hyst_lvl`.
- R5: In stall mode (`stall_mode`=1), a packet that does not fit is held with `in_ready` low and nothing is lost. `stall_req` is high from the cycle after each cycle in which the held first beat is refused.
- R6: A packet whose beat count exceeds DEPTH can never fit. It is dropped in either mode.
- R7: While `en` is low, `in_ready` is low and nothing is written, and `stall_req` is low from the next cycle. Any pending synchronization word and any hysteresis wait are cleared, so the first packet after re-enabling is forwarded without a synchronization word.
- R8: `ovf_flag` rises on the first drop and stays high until reset. `drop_cnt` increments once per dropped packet and saturates at 2^CNT_W-1.
- R9: `out_valid` is high whenever the FIFO holds a beat. Beats leave in the order they were written, one per cycle in which `out_valid` and `out_ready` are both high.
- R10: After reset, the FIFO is empty, `stall_req`, `ovf_flag` and `drop_cnt` are zero, and no beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| stall_mode | input | 1 | 1 = hold the hart on lack of room, 0 = drop packets |
| hyst_lvl | input | $clog2(DEPTH)+1 | Occupancy at or below which admission resumes after a drop |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Input beat; the first beat carries the length field |
| in_last | input | 1 | Marks the final beat of a packet |
| in_ready | output | 1 | Input beat taken this cycle |
| stall_req | output | 1 | Stall request to the hart |
| out_valid | output | 1 | FIFO holds a beat |
| out_data | output | DATA_W | Oldest FIFO beat |
| out_last | output | 1 | Last marker of the oldest beat |
| out_ready | input | 1 | Downstream takes the oldest beat |
| ovf_flag | output | 1 | Sticky loss indicator |
| drop_cnt | output | CNT_W | Saturating count of dropped packets |

## Verification
Two things can land in the same cycle: the FIFO drains to the hysteresis level, and a new first beat arrives. In that cycle the block must decide between dropping the packet and inserting the synchronization word. A FIFO read can also coincide with that admission test. These collisions are provoked by random `out_ready` throttling, random hysteresis levels and random packet lengths, including oversize ones. A cycle-level reference model in the bench predicts `in_ready`, every FIFO beat, the stall request and the status on every cycle, and the bench compares all of these.

// File: rtl/trc_ovf_pkg.sv
`timescale 1ns/1ps
package trc_ovf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_DROP} adm_state_t;
  localparam logic [3:0] SYNC_TYPE = 4'hF;
endpackage

// File: rtl/trc_ovf_fifo.sv
`timescale 1ns/1ps
module trc_ovf_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH):0]     cnt,
  output logic                       nonempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + AW'(1);
      if (rd_en) rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data  = mem[rp_q];
  assign cnt      = cnt_q;
  assign nonempty = (cnt_q != '0);
endmodule

// File: rtl/trc_ovf_admit.sv
`timescale 1ns/1ps
module trc_ovf_admit
  import trc_ovf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    stall_mode,
  input  logic [$clog2(DEPTH):0]  hyst_lvl,
  input  logic [$clog2(DEPTH):0]  fifo_cnt,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    in_last,
  output logic                    in_ready,
  output logic                    wr_en,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    wr_last,
  output logic                    stall_req,
  output logic                    drop_pulse
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int CMP_W = (LEN_W + 2 > CW) ? LEN_W + 2 : CW;
  localparam logic [DATA_W-1:0] SYNC_WORD = {SYNC_TYPE, {(DATA_W-4){1'b0}}};

  adm_state_t       st_q, st_d;
  logic             wait_q, sync_q, stall_q;
  logic [CMP_W-1:0] beats, need, room;
  logic             oversize, blocked, fits, emit, hold;

  // admission arithmetic on the first beat
  assign beats    = CMP_W'(in_data[LEN_W-1:0]) + CMP_W'(1);
  assign need     = beats + CMP_W'(sync_q);
  assign room     = CMP_W'(DEPTH) - CMP_W'(fifo_cnt);
  assign oversize = beats > CMP_W'(DEPTH);
  assign blocked  = wait_q && (fifo_cnt > hyst_lvl);
  assign fits     = !blocked && (need <= room);

  always_comb begin
    st_d       = st_q;
    in_ready   = 1'b0;
    wr_en      = 1'b0;
    wr_data    = in_data;
    wr_last    = in_last;
    drop_pulse = 1'b0;
    emit       = 1'b0;
    hold       = 1'b0;
    if (!en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            if (oversize) begin
              in_ready   = 1'b1;
              drop_pulse = 1'b1;
              if (!in_last) st_d = ST_DROP;
            end else if (fits) begin
              wr_en = 1'b1;
              if (sync_q) begin
                emit    = 1'b1;
                wr_data = SYNC_WORD;
                wr_last = 1'b1;
              end else begin
                in_ready = 1'b1;
                if (!in_last) st_d = ST_FWD;
              end
            end else if (stall_mode) begin
              hold = 1'b1;
            end else begin
              in_ready   = 1'b1;
              drop_pulse = 1'b1;
              if (!in_last) st_d = ST_DROP;
            end
          end
        end
        ST_FWD: begin
          in_ready = 1'b1;
          wr_en    = in_valid;
          if (in_valid && in_last) st_d = ST_IDLE;
        end
        ST_DROP: begin
          in_ready = 1'b1;
          if (in_valid && in_last) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      wait_q  <= 1'b0;
      sync_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stall_q <= hold;
      if (!en) begin
        wait_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        wait_q <= drop_pulse || (wait_q && (fifo_cnt > hyst_lvl));
        if (drop_pulse)  sync_q <= 1'b1;
        else if (emit)   sync_q <= 1'b0;
      end
    end
  end

  assign stall_req = stall_q;
endmodule

// File: rtl/trc_ovf_stat.sv
`timescale 1ns/1ps
module trc_ovf_stat #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drop_pulse,
  output logic             ovf_flag,
  output logic [CNT_W-1:0] drop_cnt
);
  logic             ovf_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      cnt_q <= '0;
    end else if (drop_pulse) begin
      ovf_q <= 1'b1;
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign ovf_flag = ovf_q;
  assign drop_cnt = cnt_q;
endmodule

// File: rtl/trc_ovf_ctrl.sv
`timescale 1ns/1ps
module trc_ovf_ctrl #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    stall_mode,
  input  logic [$clog2(DEPTH):0]  hyst_lvl,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    in_last,
  output logic                    in_ready,
  output logic                    stall_req,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_last,
  input  logic                    out_ready,
  output logic                    ovf_flag,
  output logic [CNT_W-1:0]        drop_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DATA_W + 1;

  logic              wr_en, wr_last, drop_pulse, pop, nonempty;
  logic [DATA_W-1:0] wr_data;
  logic [AW:0]       fifo_cnt;
  logic [EW-1:0]     rd_entry;

  trc_ovf_admit #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_admit (
    .clk(clk), .rst(rst), .en(en), .stall_mode(stall_mode),
    .hyst_lvl(hyst_lvl), .fifo_cnt(fifo_cnt),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .wr_en(wr_en), .wr_data(wr_data),
    .wr_last(wr_last), .stall_req(stall_req), .drop_pulse(drop_pulse)
  );

  assign pop = nonempty && out_ready;

  trc_ovf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data({wr_last, wr_data}),
    .rd_en(pop), .rd_data(rd_entry), .cnt(fifo_cnt), .nonempty(nonempty)
  );

  trc_ovf_stat #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst), .drop_pulse(drop_pulse),
    .ovf_flag(ovf_flag), .drop_cnt(drop_cnt)
  );

  assign out_valid = nonempty;
  assign out_data  = rd_entry[DATA_W-1:0];
  assign out_last  = rd_entry[DATA_W];
endmodule

// File: rtl/trc_ovf_chk.sv
`timescale 1ns/1ps
module trc_ovf_chk
  import trc_ovf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   wr_en,
  input logic [$clog2(DEPTH):0] fifo_cnt,
  input logic                   stall_req,
  input logic                   out_valid,
  input logic [DATA_W-1:0]      out_data,
  input logic                   out_last,
  input logic                   ovf_flag,
  input logic [CNT_W-1:0]       drop_cnt
);
  localparam logic [DATA_W-1:0] SYNC_WORD = {SYNC_TYPE, {(DATA_W-4){1'b0}}};

  // R1
  wr_room_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (fifo_cnt < ($clog2(DEPTH)+1)'(DEPTH)));

  // R9
  occ_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fifo_cnt == $past(fifo_cnt)) || (fifo_cnt == $past(fifo_cnt) + 1'b1)
             || (fifo_cnt + 1'b1 == $past(fifo_cnt)));

  // R3
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data == SYNC_WORD) |-> out_last);

  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_req) |-> ($past(in_valid) && !$past(in_ready)));

  // R7
  en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !stall_req);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1));
endmodule

bind trc_ovf_ctrl trc_ovf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_ready(in_ready),
  .wr_en(wr_en), .fifo_cnt(fifo_cnt), .stall_req(stall_req),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .ovf_flag(ovf_flag), .drop_cnt(drop_cnt)
);

// File: tb/sim_trc_ovf_ctrl.sv
`timescale 1ns/1ps
module sim_trc_ovf_ctrl;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 4;
  localparam int CNT_W  = 4;
  localparam int HW     = $clog2(DEPTH) + 1;
  localparam int DC_MAX = (1 << CNT_W) - 1;
  localparam logic [DATA_W-1:0] SYNC = {4'hF, {(DATA_W-4){1'b0}}};

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, stall_mode = 1'b0;
  logic [HW-1:0] hyst_lvl = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, stall_req, out_valid, out_last, ovf_flag;
  logic [DATA_W-1:0] out_data;
  logic [CNT_W-1:0] drop_cnt;

  always #2.5 clk = ~clk;

  trc_ovf_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .stall_mode(stall_mode), .hyst_lvl(hyst_lvl),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .stall_req(stall_req), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready), .ovf_flag(ovf_flag), .drop_cnt(drop_cnt)
  );

  int checks = 0, errs = 0;
  bit done = 0, rnd_out = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state (value after the next clock edge)
  logic [DATA_W:0] mq[$];
  logic [DATA_W:0] popped[$];
  int m_state = 0, m_dc = 0;
  bit m_wait = 0, m_sync = 0, m_stall = 0, m_ovf = 0;

  task automatic model_step();
    int sz = mq.size();
    int free = DEPTH - sz;
    int beats = int'(in_data[LEN_W-1:0]) + 1;
    bit blocked = m_wait && (sz > int'(hyst_lvl));
    bit over = beats > DEPTH;
    bit fit = !blocked && (beats + int'(m_sync) <= free);
    bit ex_rdy = 0, wr = 0, drop = 0, emit = 0, hold = 0;
    logic [DATA_W:0] wd = '0;
    int ns = m_state;
    chk(out_valid === (sz != 0), "R9 out_valid", out_valid, sz != 0);
    if (sz != 0) chk({out_last, out_data} === mq[0], "R9 out beat", {out_last, out_data}, mq[0]);
    chk(stall_req === m_stall, "R5 stall_req", stall_req, m_stall);
    chk(ovf_flag === m_ovf, "R8 ovf_flag", ovf_flag, m_ovf);
    chk(int'(drop_cnt) == m_dc, "R8 drop_cnt", drop_cnt, m_dc);
    if (!en) ns = 0;
    else if (m_state == 0) begin
      if (in_valid) begin
        if (over || (!fit && !stall_mode)) begin
          ex_rdy = 1; drop = 1;
          if (!in_last) ns = 2;
        end else if (fit) begin
          wr = 1;
          if (m_sync) begin emit = 1; wd = {1'b1, SYNC}; end
          else begin
            ex_rdy = 1; wd = {in_last, in_data};
            if (!in_last) ns = 1;
          end
        end else hold = 1;
      end
    end else if (m_state == 1) begin
      ex_rdy = 1;
      if (in_valid) begin wr = 1; wd = {in_last, in_data}; if (in_last) ns = 0; end
    end else begin
      ex_rdy = 1;
      if (in_valid && in_last) ns = 0;
    end
    chk(in_ready === ex_rdy, "R1 in_ready", in_ready, ex_rdy);
    if (sz != 0 && out_ready) popped.push_back(mq.pop_front());
    if (wr) mq.push_back(wd);
    if (!en) begin m_sync = 0; m_wait = 0; end
    else begin
      m_wait = drop || (m_wait && sz > int'(hyst_lvl));
      if (drop) m_sync = 1; else if (emit) m_sync = 0;
    end
    m_stall = hold;
    if (drop) begin m_ovf = 1; if (m_dc < DC_MAX) m_dc++; end
    m_state = ns;
  endtask

  always @(negedge clk) if (!rst) model_step();

  always @(posedge clk) if (rnd_out) begin #1; out_ready = ($urandom % 4) != 0; end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_beat(logic [DATA_W-1:0] d, logic l);
    in_valid = 1; in_data = d; in_last = l;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic send(int len, bit gaps);
    for (int b = 0; b <= len; b++) begin
      if (gaps) step($urandom % 3);
      if (b == 0) drive_beat({4'h1, 24'($urandom), 4'(len)}, len == 0);
      else drive_beat($urandom, b == len);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int dcb;
    void'($urandom(32'h5eed_71c3));
    step(5);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 0, "R10 in_ready", in_ready, 0);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(stall_req == 0 && ovf_flag == 0 && drop_cnt == 0, "R10 status", {stall_req, ovf_flag, drop_cnt}, 0);
    @(posedge clk); #1;

    // R2 / R4 / R3: drop, hysteresis, resync
    stall_mode = 0; hyst_lvl = 2; out_ready = 0; popped.delete();
    send(2, 0); send(2, 0); send(2, 0); send(0, 0);
    @(negedge clk);
    chk(drop_cnt == 2, "R4 fitting packet dropped during wait", drop_cnt, 2);
    chk(ovf_flag == 1, "R2 overflow seen", ovf_flag, 1);
    @(posedge clk); #1;
    out_ready = 1; step(12); send(1, 0); step(12);
    chk(popped.size() == 9, "R3 beat total", popped.size(), 9);
    if (popped.size() >= 8) begin
      chk(popped[6] == {1'b1, SYNC}, "R3 sync beat", popped[6], {1'b1, SYNC});
      chk(popped[7][DATA_W-1 -: 4] == 4'h1 && popped[7][3:0] == 4'd1, "R3 packet after sync",
          popped[7], 64'h1);
    end

    // R5: stall, no loss
    stall_mode = 1; out_ready = 0; popped.delete(); dcb = drop_cnt;
    fork
      begin send(3, 0); send(3, 0); send(0, 0); end
      begin
        step(14);
        @(negedge clk);
        chk(in_valid && !in_ready, "R5 held", in_ready, 0);
        chk(stall_req == 1, "R5 stall raised", stall_req, 1);
        @(posedge clk); #1;
        out_ready = 1;
      end
    join
    step(12);
    chk(popped.size() == 9, "R5 no loss", popped.size(), 9);
    chk(int'(drop_cnt) == dcb, "R5 no drop", drop_cnt, dcb);

    // R6: oversize dropped in stall mode
    popped.delete(); dcb = drop_cnt;
    send(9, 0);
    @(negedge clk);
    chk(int'(drop_cnt) == dcb + 1, "R6 oversize drop", drop_cnt, dcb + 1);
    @(posedge clk); #1;
    step(3);
    chk(popped.size() == 0, "R6 nothing forwarded", popped.size(), 0);
    send(0, 0); step(6);

    // R7: disable clears pending sync
    stall_mode = 0; out_ready = 0; hyst_lvl = 0;
    send(7, 0); send(0, 0);
    en = 0; in_valid = 1; in_data = {4'h1, 28'h0}; in_last = 1;
    @(negedge clk);
    chk(in_ready == 0, "R7 no intake while off", in_ready, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(stall_req == 0, "R7 no stall while off", stall_req, 0);
    @(posedge clk); #1;
    in_valid = 0; out_ready = 1; step(10);
    popped.delete(); en = 1; step(1);
    send(0, 0); step(5);
    chk(popped.size() == 1, "R7 single beat after enable", popped.size(), 1);
    if (popped.size() == 1)
      chk(popped[0][DATA_W-1 -: 4] == 4'h1, "R7 no sync after enable", popped[0][DATA_W-1 -: 4], 1);

    // R8: saturation
    out_ready = 0;
    send(7, 0);
    for (int i = 0; i < 20; i++) send(0, 0);
    @(negedge clk);
    chk(drop_cnt == DC_MAX, "R8 saturate", drop_cnt, DC_MAX);
    @(posedge clk); #1;
    out_ready = 1; step(12);

    // random mix: drains racing admission (R1 R4 R9)
    rnd_out = 1;
    for (int i = 0; i < 1500; i++) begin
      if (i % 100 == 0) stall_mode = $urandom % 2;
      if (i % 7 == 0) hyst_lvl = HW'($urandom % DEPTH);
      if ($urandom % 50 == 0) begin en = 0; step(1 + $urandom % 3); en = 1; end
      send(($urandom % 16 == 0) ? 8 + int'($urandom % 4) : int'($urandom % 6), 1);
    end
    rnd_out = 0; step(2); out_ready = 1; step(20);
    chk(mq.size() == 0, "R9 drained", mq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule